// File: doc/BRIEF.md
# Selectable-Order Five-Lane Serializer

This block turns parallel words arriving on a narrow host path into a single serial bit stream. It runs on the bit-rate clock. A load strobe hands it a new word once every `WORD_W` cycles, and the block then drives that word out one bit per cycle. Consecutive words join into a gapless stream. A wider symbol, such as a 10-bit code, is sent as two consecutive words with its less significant half first.

A small address/data/write-enable configuration port holds a single order bit. With the bit clear, lane 0 of each word leaves first. With it set, the highest lane leaves first. A new order is applied only when the next word is accepted, so no word is ever split between two orders. A write of bit 0 = 1 to the soft-reset address returns the configuration to its default.

A strobe that arrives while a word is still being shifted is rejected, and it sets a sticky overrun flag. If the strobe is missing at the word boundary, the serial-valid output drops and the block waits for the next strobe.

Top module: `quint_serializer`

## Requirements
- R1: After synchronous reset (`rst` high for a clock), `sdo`, `sdo_valid` and `overrun` are 0, and the order bit is 0 (lane 0 first).
- R2: A `load` while `sdo_valid` is 0 latches `din`. From the next cycle, `sdo_valid` is 1, and over `WORD_W` cycles `sdo` carries `din[0]`, `din[1]`, … `din[WORD_W-1]` in the default order.
- R3: With order bit 1 (register address 0x2E, data bit 0 = 1), a word is sent `din[WORD_W-1]` first, down to `din[0]` last.
- R4: With a `load` on every `WORD_W`-th cycle, the output has no gap. A 10-bit symbol T presented as T[4:0] and then T[9:5] leaves as T0 first through T9 last.
- R5: A `load` while a word is shifting and not at its last bit is ignored, so the stream is unchanged. It sets `overrun`, which stays 1 until `rst`.
- R6: An order write during a word does not change that word. It applies from the next accepted word on.
- R7: If no `load` arrives while the last bit of a word is shown, `sdo_valid` and `sdo` go to 0 on the next cycle. A later `load` at any cycle is then accepted as in R2.
- R8: A write to address 0x00 with data bit 0 = 1 clears the order bit. Writes to any other address, or to 0x00 with bit 0 = 0, leave the order unchanged.
- R9: `rst` clears a set `overrun`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Word strobe |
| din | input | WORD_W | Parallel word, lane 0 = bit 0 |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | ADDR_W | Configuration address |
| cfg_wdata | input | DATA_W | Configuration write data |
| sdo | output | 1 | Serial data |
| sdo_valid | output | 1 | Serial data valid |
| overrun | output | 1 | Sticky misplaced-strobe flag |

## Verification
The bench builds two copies with `WORD_W = 5` and the 0x2E/0x00 addresses. One uses `OUT_STYLE = 0` (shift register) and the other `OUT_STYLE = 1` (held word with indexed output). Both are driven in lockstep against one queue-based model. This lets the bench show that the two output variants match bit for bit across order changes, misplaced strobes and underflow. The five-lane width brings the two-half 10-bit symbol case within reach.

// File: rtl/qser_pkg.sv
package qser_pkg;
   typedef enum logic [0:0] {
      ORD_LOW_FIRST  = 1'b0,
      ORD_HIGH_FIRST = 1'b1
   } order_e;

   localparam int unsigned OUT_SHIFT = 0;
   localparam int unsigned OUT_INDEX = 1;
endpackage

// File: rtl/qser_cfg_regs.sv
module qser_cfg_regs
   import qser_pkg::*;
#(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned ORDER_ADDR = 'h2E,
   parameter int unsigned SRST_ADDR  = 'h00,
   parameter int unsigned ORDER_BIT  = 0,
   parameter int unsigned SRST_BIT   = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output order_e            order_o
);
   localparam logic [ADDR_W-1:0] A_ORDER = ADDR_W'(ORDER_ADDR);
   localparam logic [ADDR_W-1:0] A_SRST  = ADDR_W'(SRST_ADDR);

   if (ORDER_BIT >= DATA_W) begin : g_bad_obit
      $error("ORDER_BIT outside data word");
   end
   if (SRST_BIT >= DATA_W) begin : g_bad_sbit
      $error("SRST_BIT outside data word");
   end
   if (A_ORDER == A_SRST) begin : g_bad_addr
      $error("order and soft-reset addresses collide");
   end

   logic   hit_order;
   logic   hit_srst;
   order_e order_q;

   assign hit_order = we && (addr == A_ORDER);
   assign hit_srst  = we && (addr == A_SRST) && wdata[SRST_BIT];

   always_ff @(posedge clk) begin
      if (rst) begin
         order_q <= ORD_LOW_FIRST;
      end else if (hit_srst) begin
         order_q <= ORD_LOW_FIRST;
      end else if (hit_order) begin
         order_q <= order_e'(wdata[ORDER_BIT]);
      end
   end

   logic unused_wdata;
   assign unused_wdata = ^wdata;

   assign order_o = order_q;
endmodule

// File: rtl/qser_slot_tracker.sv
module qser_slot_tracker #(
   parameter int unsigned WORD_W = 5,
   localparam int unsigned CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   output logic             accept_o,
   output logic             running_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic             overrun_o
);
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

   logic             running_q;
   logic [CNT_W-1:0] cnt_q;
   logic             ovr_q;
   logic             at_last;
   logic             misplaced;

   assign at_last   = running_q && (cnt_q == LAST_IDX);
   assign accept_o  = load && (!running_q || at_last);
   assign misplaced = load && running_q && !at_last;

   always_ff @(posedge clk) begin
      if (rst) begin
         running_q <= 1'b0;
         cnt_q     <= '0;
      end else if (accept_o) begin
         running_q <= 1'b1;
         cnt_q     <= '0;
      end else if (at_last) begin
         running_q <= 1'b0;
         cnt_q     <= '0;
      end else if (running_q) begin
         cnt_q     <= cnt_q + CNT_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ovr_q <= 1'b0;
      end else if (misplaced) begin
         ovr_q <= 1'b1;
      end
   end

   assign running_o = running_q;
   assign cnt_o     = cnt_q;
   assign overrun_o = ovr_q;
endmodule

// File: rtl/qser_out_stage.sv
module qser_out_stage
   import qser_pkg::*;
#(
   parameter int unsigned WORD_W    = 5,
   parameter int unsigned OUT_STYLE = OUT_SHIFT,
   localparam int unsigned CNT_W    = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              accept,
   input  logic              running,
   input  logic [CNT_W-1:0]  cnt,
   input  order_e            order,
   input  logic [WORD_W-1:0] din,
   output logic              sdo
);
   logic [WORD_W-1:0] din_rev;
   logic [WORD_W-1:0] din_ord;

   for (genvar i = 0; i < WORD_W; i++) begin : g_rev
      assign din_rev[i] = din[WORD_W-1-i];
   end

   assign din_ord = (order == ORD_HIGH_FIRST) ? din_rev : din;

   if (OUT_STYLE == OUT_SHIFT) begin : g_shift
      logic [WORD_W-1:0] sh_q;
      always_ff @(posedge clk) begin
         if (rst) begin
            sh_q <= '0;
         end else if (accept) begin
            sh_q <= din_ord;
         end else begin
            sh_q <= {1'b0, sh_q[WORD_W-1:1]};
         end
      end
      logic unused_idx;
      assign unused_idx = running ^ (^cnt);
      assign sdo = sh_q[0];
   end else if (OUT_STYLE == OUT_INDEX) begin : g_index
      logic [WORD_W-1:0] word_q;
      always_ff @(posedge clk) begin
         if (rst) begin
            word_q <= '0;
         end else if (accept) begin
            word_q <= din_ord;
         end
      end
      assign sdo = running && word_q[cnt];
   end else begin : g_bad_style
      $error("OUT_STYLE must be 0 or 1");
   end
endmodule

// File: rtl/quint_serializer.sv
module quint_serializer
   import qser_pkg::*;
#(
   parameter int unsigned WORD_W     = 5,
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned ORDER_ADDR = 'h2E,
   parameter int unsigned SRST_ADDR  = 'h00,
   parameter int unsigned ORDER_BIT  = 0,
   parameter int unsigned SRST_BIT   = 0,
   parameter int unsigned OUT_STYLE  = OUT_SHIFT
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [WORD_W-1:0] din,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic              sdo,
   output logic              sdo_valid,
   output logic              overrun
);
   localparam int unsigned CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;

   if (WORD_W < 2) begin : g_bad_width
      $error("WORD_W must be at least 2");
   end
   if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_aw
      $error("ADDR_W must be 1..16");
   end
   if (ORDER_ADDR >= (1 << ADDR_W) || SRST_ADDR >= (1 << ADDR_W)) begin : g_bad_map
      $error("configuration address does not fit ADDR_W");
   end

   order_e           order;
   logic             accept;
   logic             running;
   logic [CNT_W-1:0] cnt;

   qser_cfg_regs #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .ORDER_ADDR(ORDER_ADDR),
      .SRST_ADDR (SRST_ADDR),
      .ORDER_BIT (ORDER_BIT),
      .SRST_BIT  (SRST_BIT)
   ) u_cfg (
      .clk    (clk),
      .rst    (rst),
      .we     (cfg_we),
      .addr   (cfg_addr),
      .wdata  (cfg_wdata),
      .order_o(order)
   );

   qser_slot_tracker #(
      .WORD_W(WORD_W)
   ) u_slot (
      .clk      (clk),
      .rst      (rst),
      .load     (load),
      .accept_o (accept),
      .running_o(running),
      .cnt_o    (cnt),
      .overrun_o(overrun)
   );

   qser_out_stage #(
      .WORD_W   (WORD_W),
      .OUT_STYLE(OUT_STYLE)
   ) u_out (
      .clk    (clk),
      .rst    (rst),
      .accept (accept),
      .running(running),
      .cnt    (cnt),
      .order  (order),
      .din    (din),
      .sdo    (sdo)
   );

   assign sdo_valid = running;
endmodule

// File: rtl/qser_checker.sv
module qser_checker (
   input logic clk,
   input logic rst,
   input logic load,
   input logic sdo,
   input logic sdo_valid,
   input logic overrun
);
   // R1: state after reset
   a_r1_idle_after_reset: assert property (@(posedge clk)
      rst |=> (!sdo_valid && !sdo && !overrun));

   // R2: a strobe while idle starts output
   a_r2_idle_load_starts: assert property (@(posedge clk) disable iff (rst)
      (load && !sdo_valid) |=> sdo_valid);

   // R5: overrun is sticky
   a_r5_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
      overrun |=> overrun);

   // R5: overrun rises only after a strobe
   a_r5_overrun_needs_load: assert property (@(posedge clk) disable iff (rst)
      $rose(overrun) |-> $past(load));

   // R7: output quiet when not valid
   a_r7_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
      !sdo_valid |-> !sdo);

   // R7: valid falls only when no strobe came
   a_r7_fall_without_load: assert property (@(posedge clk) disable iff (rst)
      $fell(sdo_valid) |-> !$past(load));
endmodule

bind quint_serializer qser_checker u_chk (
   .clk      (clk),
   .rst      (rst),
   .load     (load),
   .sdo      (sdo),
   .sdo_valid(sdo_valid),
   .overrun  (overrun)
);

// File: tb/quint_serializer_tb_top.sv
module quint_serializer_tb_top;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       load = 1'b0;
   logic [4:0] din = '0;
   logic       cfg_we = 1'b0;
   logic [7:0] cfg_addr = '0;
   logic [7:0] cfg_wdata = '0;

   logic sdo_a, val_a, ovr_a;
   logic sdo_b, val_b, ovr_b;

   always #5 clk = ~clk;

   quint_serializer #(.OUT_STYLE(0)) dut_i (
      .clk(clk), .rst(rst), .load(load), .din(din),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .sdo(sdo_a), .sdo_valid(val_a), .overrun(ovr_a));

   quint_serializer #(.OUT_STYLE(1)) dut_mux_i (
      .clk(clk), .rst(rst), .load(load), .din(din),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .sdo(sdo_b), .sdo_valid(val_b), .overrun(ovr_b));

   int    n_vec = 0;
   int    n_bad = 0;
   bit    done = 0;
   string req = "R1";

   bit   m_run = 0;
   bit   m_ovr = 0;
   bit   m_pend = 0;
   bit   m_q[$];

   task automatic chk(input string r, input string what, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", r, what, act, exp, $time);
      end
   endtask

   task automatic push_word(input logic [4:0] d);
      for (int i = 0; i < 5; i++) m_q.push_back(m_pend ? d[4-i] : d[i]);
   endtask

   task automatic tick();
      if (rst) begin
         m_run = 0; m_ovr = 0; m_pend = 0; m_q.delete();
      end else begin
         if (m_run) begin
            if (m_q.size() == 1) begin
               m_q.delete();
               if (load) push_word(din); else m_run = 0;
            end else begin
               if (load) m_ovr = 1;
               void'(m_q.pop_front());
            end
         end else if (load) begin
            push_word(din);
            m_run = 1;
         end
         if (cfg_we) begin
            if (cfg_addr == 8'h00 && cfg_wdata[0]) m_pend = 0;
            else if (cfg_addr == 8'h2E) m_pend = cfg_wdata[0];
         end
      end
      @(posedge clk);
      #1;
      begin
         int exp_sdo = (m_run && m_q.size() > 0) ? int'(m_q[0]) : 0;
         chk(req, "sdo", int'(sdo_a), exp_sdo);
         chk(req, "sdo_valid", int'(val_a), int'(m_run));
         chk(req, "overrun", int'(ovr_a), int'(m_ovr));
         chk(req, "sdo idx", int'(sdo_b), exp_sdo);
         chk(req, "sdo_valid idx", int'(val_b), int'(m_run));
         chk(req, "overrun idx", int'(ovr_b), int'(m_ovr));
      end
      load = 0; cfg_we = 0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic put(input logic [4:0] d);
      load = 1; din = d; tick();
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] w);
      cfg_we = 1; cfg_addr = a; cfg_wdata = w; tick();
   endtask

   task automatic symbol(input logic [9:0] s, input string r);
      logic [9:0] got;
      for (int i = 0; i < 10; i++) begin
         if (i == 0) begin load = 1; din = s[4:0]; end
         if (i == 5) begin load = 1; din = s[9:5]; end
         tick();
         got[i] = sdo_a;
      end
      chk(r, "symbol T0..T9", int'(got), int'(s));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL R2 watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      logic [4:0] cap;
      #1;
      req = "R1";
      rst = 1; idle(2);
      rst = 0; idle(2);

      req = "R2";
      put(5'b10110);
      cap = '0;
      cap[0] = sdo_a;
      for (int i = 1; i < 5; i++) begin tick(); cap[i] = sdo_a; end
      chk("R2", "lane0-first word", int'(cap), int'(5'b10110));
      req = "R7";
      tick();
      chk("R7", "valid after missing strobe", int'(val_a), 0);
      idle(3);
      put(5'b00111); idle(4); idle(2);

      req = "R3";
      wr(8'h2E, 8'h01); idle(1);
      put(5'b10011);
      cap = '0;
      cap[0] = sdo_a;
      for (int i = 1; i < 5; i++) begin tick(); cap[i] = sdo_a; end
      chk("R3", "lane4-first word", int'(cap), int'(5'b11001));
      idle(2);

      req = "R4";
      wr(8'h2E, 8'h00);
      symbol(10'h2A5, "R4");
      symbol(10'h0F3, "R4");
      symbol(10'h3FF, "R4");
      symbol(10'h001, "R4");
      idle(2);

      req = "R5";
      put(5'b01101); tick();
      put(5'b11111);
      chk("R5", "overrun set", int'(ovr_a), 1);
      idle(2);
      put(5'b00000);
      idle(5);
      chk("R5", "overrun sticky", int'(ovr_a), 1);

      req = "R9";
      rst = 1; tick(); rst = 0; tick();
      chk("R9", "overrun cleared", int'(ovr_a), 0);

      req = "R6";
      put(5'b00011); tick();
      wr(8'h2E, 8'h01);
      tick(); tick();
      put(5'b00011); idle(4); tick();

      req = "R8";
      wr(8'h10, 8'h00); wr(8'h00, 8'h00);
      put(5'b00001);
      chk("R8", "order kept after unrelated writes", int'(sdo_a), 0);
      idle(5);
      wr(8'h00, 8'h01);
      put(5'b00001);
      chk("R8", "soft reset restores lane0 first", int'(sdo_a), 1);
      idle(6);

      req = "R7";
      tick(); put(5'b10101); idle(2); put(5'b01010); idle(4); idle(3);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule